// File: doc/BRIEF.md
# Serial-Clocked EEPROM Read Responder

This block stands in for a small serial EEPROM that software reaches only through a bit-banged control register. Software writes the register to drive the clock, select and data-in lines, and reads it to sample the data-out line. Once selected, the responder collects a 9-bit command of a 3-bit opcode and a 6-bit word address, sent first bit first. If the opcode is the read code, it streams the stored words out most significant bit first, one bit per rising clock edge. The stream runs on into the following words for as long as the clock keeps toggling. Opcodes other than read are accepted and then ignored.

The 64 x 16-bit word array is filled through a parallel load port. A second register gives software a direct word fetch. A write with the go bit set and a word index returns the word, the echoed index and a done flag on the next cycle, with no serial traffic.

Top module: `seeprom_resp`

## Requirements
- R1: A control write stores only its clock (bit 0), select (bit 1) and data-in (bit 2) values. A control read returns those stored bits at the same positions, data-out at bit 3, constant 1 at bits 8 and 9, and 0 in every other bit.
- R2: A control write with select 0 cancels any read in progress and clears the command shift value and its bit count. The next command must again be sent in full with 9 rising edges.
- R3: A rising edge is a control write with select 1 and clock 1 while the previously stored clock was 0. Only a rising edge shifts data-in into the command or advances the output. Writes that hold the clock high or drop it have no effect on either.
- R4: On the 9th rising edge, the first three bits sent form the opcode and the last six the address A. If the opcode is 3'b110, a read starts, and data-out at that point shows bit 0 of word (A-1) mod 64.
- R5: During a read, each further rising edge moves data-out to the next bit. The k-th edge after the command (k from 1) shows bit 15-((k-1) mod 16) of word (A+(k-1)/16) mod 64, so each word appears MSB first.
- R6: A read that runs past word 63 continues with word 0. When A is 0, the bit shown at decode is bit 0 of word 63.
- R7: For any opcode other than 3'b110 no read starts, data-out stays 1 on further edges, and the command is not decoded a second time until select is dropped.
- R8: While no read is active, data-out reads as 1.
- R9: A load-port strobe writes its 16-bit data into the addressed word. Both read paths return the new value from the next cycle on.
- R10: A direct-fetch write with go set and index I makes the fetch register read the word in bits 31:16, I in bits 13:8, done (bit 4) as 1 and go (bit 0) as 0 on the next cycle. A write with go clear returns only I in bits 13:8, with done and the data field at 0.
- R11: After reset, every word is 0, the control read value is 0x308, and the fetch register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe, one access per strobed cycle |
| ctl_wdata | input | 3 | Written clock (0), select (1), data-in (2) |
| ctl_rdata | output | 32 | Control register read value |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | 6 | Word address for the load |
| ld_data | input | 16 | Word data for the load |
| fetch_wr | input | 1 | Direct-fetch register write strobe |
| fetch_go | input | 1 | Go bit of the direct-fetch write |
| fetch_idx | input | 6 | Word index of the direct-fetch write |
| fetch_rdata | output | 32 | Direct-fetch register read value |

## Verification
The properties assume that every cycle with a write strobe counts as exactly one register access. A strobe held for two cycles is two accesses, the second of which sees the first one's clock and so is not a rising edge. They also assume that strobes and write data are free of X after reset. The bench issues each access as a one-cycle strobe set up at a falling clock edge, with idle cycles between. It loads the array only before any serial sequence starts, so the streamed bits never depend on a load that races them.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

   // control register read layout
   localparam int CB_SCK  = 0;
   localparam int CB_SEL  = 1;
   localparam int CB_DIN  = 2;
   localparam int CB_DOUT = 3;
   localparam int CB_PRES = 8;
   localparam int CB_GNT  = 9;

   // direct fetch register read layout
   localparam int DR_GO     = 0;
   localparam int DR_DONE   = 4;
   localparam int DR_IDX_LO = 8;

   typedef struct packed {
      logic din;
      logic sel;
      logic sck;
   } ctl_bits_t;

endpackage

// File: rtl/seeprom_words.sv
module seeprom_words #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [WORD_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] a_addr,
   output logic [WORD_W-1:0] a_word,
   input  logic [ADDR_W-1:0] b_addr,
   output logic [WORD_W-1:0] b_word
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (ld_en && (ld_addr == ADDR_W'(w)))
            q <= ld_data;
      end
      assign words[w] = q;
   end

   assign a_word = words[a_addr];
   assign b_word = words[b_addr];

endmodule

// File: rtl/seeprom_serial.sv
module seeprom_serial #(
   parameter int              WORD_W = 16,
   parameter int              ADDR_W = 6,
   parameter int              OPC_W  = 3,
   parameter logic [OPC_W-1:0] RD_OPC = 3'b110,
   localparam int             BIT_W  = $clog2(WORD_W),
   localparam int             CTR_W  = ADDR_W + BIT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             sel_new,
   input  logic             sck_new,
   input  logic             din_new,
   input  logic             sck_old,
   output logic             rd_active,
   output logic [CTR_W-1:0] out_ctr
);
   localparam int CMD_LEN = OPC_W + ADDR_W;
   localparam int CNT_W   = $clog2(CMD_LEN + 1);

   logic [CMD_LEN-2:0] shift_q;
   logic [CMD_LEN-1:0] shift_nx;
   logic [CNT_W-1:0]   cnt_q;
   logic [CTR_W-1:0]   ctr_q;
   logic               rd_q;
   logic               rise;
   logic               last_bit;

   assign rise     = acc && sel_new && sck_new && !sck_old;
   assign shift_nx = {shift_q, din_new};
   assign last_bit = (cnt_q == CNT_W'(CMD_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         cnt_q   <= '0;
         ctr_q   <= '0;
         rd_q    <= 1'b0;
      end else if (acc && !sel_new) begin
         shift_q <= '0;
         cnt_q   <= '0;
         ctr_q   <= '0;
         rd_q    <= 1'b0;
      end else if (rise) begin
         shift_q <= shift_nx[CMD_LEN-2:0];
         if (cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
         if (rd_q) begin
            ctr_q <= ctr_q + 1'b1;
         end else if (last_bit) begin
            ctr_q <= {shift_nx[ADDR_W-1:0], {BIT_W{1'b0}}} - 1'b1;
            rd_q  <= (shift_nx[CMD_LEN-1 -: OPC_W] == RD_OPC);
         end
      end
   end

   assign rd_active = rd_q;
   assign out_ctr   = ctr_q;

endmodule

// File: rtl/seeprom_fetch.sv
module seeprom_fetch #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_wr,
   input  logic              fetch_go,
   input  logic [ADDR_W-1:0] fetch_idx,
   input  logic [WORD_W-1:0] word,
   output logic [REG_W-1:0]  fetch_rdata
);
   import seeprom_pkg::*;

   logic [REG_W-1:0] nx;
   logic [REG_W-1:0] q;

   always_comb begin
      nx = '0;
      nx[DR_IDX_LO +: ADDR_W] = fetch_idx;
      if (fetch_go) begin
         nx[REG_W-1 -: WORD_W] = word;
         nx[DR_DONE]           = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (fetch_wr)
         q <= nx;
   end

   assign fetch_rdata = q;

endmodule

// File: rtl/seeprom_resp.sv
module seeprom_resp #(
   parameter int              WORD_W = 16,
   parameter int              ADDR_W = 6,
   parameter int              OPC_W  = 3,
   parameter logic [OPC_W-1:0] RD_OPC = 3'b110,
   parameter int              REG_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ctl_wr,
   input  logic [seeprom_pkg::CB_DIN:0]  ctl_wdata,
   output logic [REG_W-1:0]              ctl_rdata,
   input  logic                          ld_en,
   input  logic [ADDR_W-1:0]             ld_addr,
   input  logic [WORD_W-1:0]             ld_data,
   input  logic                          fetch_wr,
   input  logic                          fetch_go,
   input  logic [ADDR_W-1:0]             fetch_idx,
   output logic [REG_W-1:0]              fetch_rdata
);
   import seeprom_pkg::*;

   localparam int BIT_W = $clog2(WORD_W);
   localparam int CTR_W = ADDR_W + BIT_W;

   if (WORD_W != (1 << BIT_W)) begin : g_bad_word
      $error("WORD_W must be a power of two");
   end
   if (REG_W < WORD_W + DR_IDX_LO + ADDR_W) begin : g_bad_reg
      $error("REG_W too narrow for the fetch layout");
   end
   if (REG_W <= CB_GNT) begin : g_bad_ctl
      $error("REG_W too narrow for the control layout");
   end
   if (OPC_W < 1 || ADDR_W < 1) begin : g_bad_cmd
      $error("command fields must be non-empty");
   end

   ctl_bits_t         ctl_q;
   ctl_bits_t         ctl_new;
   logic              rd_active;
   logic [CTR_W-1:0]  out_ctr;
   logic [WORD_W-1:0] ser_word;
   logic [WORD_W-1:0] fetch_word;
   logic              dout;

   assign ctl_new = ctl_bits_t'(ctl_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (ctl_wr)
         ctl_q <= ctl_new;
   end

   seeprom_words #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_words (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .a_addr  (out_ctr[CTR_W-1:BIT_W]),
      .a_word  (ser_word),
      .b_addr  (fetch_idx),
      .b_word  (fetch_word)
   );

   seeprom_serial #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W), .RD_OPC(RD_OPC)) u_serial (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (ctl_wr),
      .sel_new   (ctl_new.sel),
      .sck_new   (ctl_new.sck),
      .din_new   (ctl_new.din),
      .sck_old   (ctl_q.sck),
      .rd_active (rd_active),
      .out_ctr   (out_ctr)
   );

   seeprom_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_wr    (fetch_wr),
      .fetch_go    (fetch_go),
      .fetch_idx   (fetch_idx),
      .word        (fetch_word),
      .fetch_rdata (fetch_rdata)
   );

   // MSB first: bit index is the complement of the low counter field
   assign dout = rd_active ? ser_word[~out_ctr[BIT_W-1:0]] : 1'b1;

   always_comb begin
      ctl_rdata          = '0;
      ctl_rdata[CB_SCK]  = ctl_q.sck;
      ctl_rdata[CB_SEL]  = ctl_q.sel;
      ctl_rdata[CB_DIN]  = ctl_q.din;
      ctl_rdata[CB_DOUT] = dout;
      ctl_rdata[CB_PRES] = 1'b1;
      ctl_rdata[CB_GNT]  = 1'b1;
   end

endmodule

// File: rtl/seeprom_checker.sv
module seeprom_checker #(
   parameter int CTR_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic [2:0]       ctl_wdata,
   input logic [2:0]       held_bits,
   input logic             dout_bit,
   input logic             fetch_wr,
   input logic             fetch_go,
   input logic             done_bit,
   input logic             go_bit,
   input logic             rd_active,
   input logic [CTR_W-1:0] out_ctr
);
   logic rise;
   assign rise = ctl_wr && ctl_wdata[1] && ctl_wdata[0] && !held_bits[0];

   AST_CTL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> held_bits == $past(ctl_wdata)); // R1

   AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[1]) |=> (!rd_active && dout_bit)); // R2

   AST_NO_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> ($stable(out_ctr) && $stable(rd_active))); // R3

   AST_CTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && rd_active) |=> (rd_active && out_ctr == CTR_W'($past(out_ctr) + 1'b1))); // R5

   AST_IDLE_DOUT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_active |-> dout_bit); // R8

   AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_wr && fetch_go) |=> (done_bit && !go_bit)); // R10

endmodule

bind seeprom_resp seeprom_checker #(.CTR_W(CTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_wr    (ctl_wr),
   .ctl_wdata (ctl_wdata),
   .held_bits (ctl_rdata[2:0]),
   .dout_bit  (ctl_rdata[3]),
   .fetch_wr  (fetch_wr),
   .fetch_go  (fetch_go),
   .done_bit  (fetch_rdata[4]),
   .go_bit    (fetch_rdata[0]),
   .rd_active (rd_active),
   .out_ctr   (out_ctr)
);

// File: tb/seeprom_resp_test.sv
`timescale 1ns/1ps
module seeprom_resp_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [2:0]  ctl_wdata = '0;
   logic [31:0] ctl_rdata;
   logic        ld_en = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic        fetch_wr = 1'b0;
   logic        fetch_go = 1'b0;
   logic [5:0]  fetch_idx = '0;
   logic [31:0] fetch_rdata;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [15:0] mem [64];

   always #5 clk = ~clk;

   seeprom_resp uut (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .fetch_wr(fetch_wr), .fetch_go(fetch_go), .fetch_idx(fetch_idx),
      .fetch_rdata(fetch_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic ctl_acc(input logic sck, input logic sel, input logic din);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = {din, sel, sck};
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic edge_bit(input logic din);
      ctl_acc(1'b0, 1'b1, din);
      ctl_acc(1'b1, 1'b1, din);
   endtask

   task automatic send_cmd(input logic [2:0] opc, input logic [5:0] addr);
      logic [8:0] c;
      c = {opc, addr};
      for (int i = 8; i >= 0; i--) edge_bit(c[i]);
   endtask

   function automatic logic exp_bit(input int addr, input int k);
      int p;
      p = (addr * 16 + 1023 + k) % 1024;
      return mem[p / 16][15 - (p % 16)];
   endfunction

   task automatic fetch(input logic go, input logic [5:0] idx);
      @(negedge clk);
      fetch_wr = 1'b1;
      fetch_go = go;
      fetch_idx = idx;
      @(negedge clk);
      fetch_wr = 1'b0;
   endtask

   task automatic stream_check(input int addr, input int nbits, input string req);
      check(ctl_rdata[3] == exp_bit(addr, 0), "R4 decode bit", {31'b0, ctl_rdata[3]}, {31'b0, exp_bit(addr, 0)});
      for (int k = 1; k <= nbits; k++) begin
         edge_bit(1'b0);
         check(ctl_rdata[3] == exp_bit(addr, k), req, {31'b0, ctl_rdata[3]}, {31'b0, exp_bit(addr, k)});
      end
   endtask

   task automatic t_reset;
      check(ctl_rdata == 32'h308, "R11 ctl reset", ctl_rdata, 32'h308);
      check(ctl_rdata[3] == 1'b1, "R8 idle dout", ctl_rdata, 32'h308);
      check(fetch_rdata == 32'h0, "R11 fetch reset", fetch_rdata, 32'h0);
      fetch(1'b1, 6'd7);
      check(fetch_rdata == 32'h0710, "R11 array zero", fetch_rdata, 32'h0710);
   endtask

   task automatic t_load;
      for (int i = 0; i < 64; i++) begin
         mem[i] = 16'(i * 16'h0931 + 16'h5A3C);
         @(negedge clk);
         ld_en = 1'b1; ld_addr = 6'(i); ld_data = mem[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
      fetch(1'b1, 6'd33);
      check(fetch_rdata == {mem[33], 16'h2110}, "R9 load", fetch_rdata, {mem[33], 16'h2110});
   endtask

   task automatic t_latch;
      ctl_acc(1'b1, 1'b0, 1'b1);
      check(ctl_rdata == 32'h30D, "R1 latch", ctl_rdata, 32'h30D);
      ctl_acc(1'b0, 1'b1, 1'b0);
      check(ctl_rdata == 32'h30A, "R1 latch sel", ctl_rdata, 32'h30A);
      ctl_acc(1'b0, 1'b0, 1'b0);
      check(ctl_rdata == 32'h308, "R1 latch clear", ctl_rdata, 32'h308);
   endtask

   task automatic t_read_plain;
      ctl_acc(1'b0, 1'b1, 1'b0);
      send_cmd(3'b110, 6'd5);
      stream_check(5, 40, "R5 stream");
      ctl_acc(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_wrap;
      ctl_acc(1'b0, 1'b1, 1'b0);
      send_cmd(3'b110, 6'd63);
      stream_check(63, 24, "R6 wrap");
      ctl_acc(1'b0, 1'b0, 1'b0);
      ctl_acc(1'b0, 1'b1, 1'b0);
      send_cmd(3'b110, 6'd0);
      stream_check(0, 3, "R6 addr0");
      ctl_acc(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_nonread;
      ctl_acc(1'b0, 1'b1, 1'b0);
      send_cmd(3'b101, 6'd9);
      check(ctl_rdata[3] == 1'b1, "R7 no read", ctl_rdata, 32'h1);
      // the next nine bits would be a read command if decoded again
      send_cmd(3'b110, 6'd2);
      for (int k = 0; k < 12; k++) begin
         edge_bit(1'b0);
         check(ctl_rdata[3] == 1'b1, "R7 stays idle", ctl_rdata, 32'h1);
      end
      ctl_acc(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_edges;
      logic [8:0] c;
      c = {3'b110, 6'd44};
      ctl_acc(1'b0, 1'b1, 1'b0);
      for (int i = 8; i >= 5; i--) edge_bit(c[i]);
      // clock held high, then dropped: neither is an edge
      ctl_acc(1'b1, 1'b1, ~c[4]);
      ctl_acc(1'b1, 1'b1, ~c[4]);
      ctl_acc(1'b0, 1'b1, ~c[4]);
      ctl_acc(1'b0, 1'b1, ~c[4]);
      check(ctl_rdata[3] == 1'b1, "R3 no edge", ctl_rdata, 32'h1);
      for (int i = 4; i >= 0; i--) edge_bit(c[i]);
      stream_check(44, 16, "R3 edge-only shift");
      ctl_acc(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_deselect;
      ctl_acc(1'b0, 1'b1, 1'b0);
      send_cmd(3'b110, 6'd12);
      for (int k = 0; k < 5; k++) edge_bit(1'b0);
      ctl_acc(1'b0, 1'b0, 1'b0);
      check(ctl_rdata[3] == 1'b1, "R2 deselect idle", ctl_rdata, 32'h1);
      ctl_acc(1'b0, 1'b1, 1'b0);
      send_cmd(3'b110, 6'd20);
      stream_check(20, 16, "R2 fresh command");
      ctl_acc(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_fetch;
      fetch(1'b0, 6'd9);
      check(fetch_rdata == 32'h0900, "R10 no go", fetch_rdata, 32'h0900);
      fetch(1'b1, 6'd63);
      check(fetch_rdata == {mem[63], 16'h3F10}, "R10 go", fetch_rdata, {mem[63], 16'h3F10});
      fetch(1'b1, 6'd0);
      check(fetch_rdata == {mem[0], 16'h0010}, "R10 go idx0", fetch_rdata, {mem[0], 16'h0010});
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_load;
      t_latch;
      t_read_plain;
      t_wrap;
      t_nonread;
      t_edges;
      t_deselect;
      t_fetch;
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule